// File: doc/BRIEF.md
# ADC Control Register Front End

This block is the software-facing register set that sits in front of an 8-input, 10-bit successive-approximation converter. A host writes and reads bytes at four offsets. Through them it enables the converter clock, picks one of eight analog inputs and launches single conversions. It also selects which source operates the external reference switch, reads back the 10-bit result and sets the level of the completion interrupt. On the converter side the block drives a gated clock enable, a one-cycle start pulse and the channel number. It accepts a completion strobe that carries the result.

The completion path is a valid/ready pair. The block raises `conv_done_ready` only while a conversion it launched is outstanding. A strobe offered at any other time is not taken and leaves the stored result untouched. The converter never has to hold `conv_done_valid`, because the block accepts on the first valid cycle of an outstanding conversion.

Register map. The control byte sits at offset 0: channel in bits 2:0, software reference bit in bit 3, touch-controller select in bit 4, start in bit 7, and bits 7:5 read 0. The result high byte sits at offset 1 and holds result bits 9:2. The result low byte sits at offset 2 and holds result bits 1:0 in bits 1:0, with bits 7:2 reading 0. The configuration byte sits at offset 3: clock enable in bit 0, interrupt level in bits 2:1, and the other bits read 0. Reads are combinational from `rd_addr`. `rd_en` only marks the read as consuming the interrupt.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, all four offsets read 0, and `adc_clk_en`, `conv_start`, `conv_busy`, `conv_done_ready`, `irq_req` and `irq_level` are 0.
- R2: `adc_clk_en` is 1 exactly when configuration bit 0 is 1 and `fast_osc_sel` is 1.
- R3: A write to offset 0 with bit 7 set raises `conv_start` for exactly the one cycle after the write edge, and it sets `conv_busy`. A write with bit 7 clear starts nothing. Bit 7 always reads 0.
- R4: Control bits 2:0 hold the channel code (0 selects AD0, 7 selects AD7), drive `conv_chan`, and read back. A start written together with a channel code converts the newly written channel.
- R5: A start request is dropped with no pulse when `conv_busy` is 1 or `adc_clk_en` is 0 at the write edge.
- R6: `conv_done_ready` equals `conv_busy`. An accepted strobe clears busy and stores all 10 result bits in the same cycle: bits 9:2 go to offset 1, and bits 1:0 go to offset 2 bits 1:0 with bits 7:2 at 0. An unaccepted strobe and writes to offsets 1 and 2 leave the result unchanged.
- R7: When control bit 4 is 0, the reference is active when control bit 3 is 1. `ref_pin_oe` follows `ref_port_oe`, and `ref_pin_level` is `ref_port_oe & ref_port_data & ~active`. This drives the pin low to switch the reference on.
- R8: When control bit 4 is 1, `tp_ref_req` alone decides whether the reference is active, and control bit 3 has no effect on the pin.
- R9: Configuration bits 2:1 hold the interrupt level, where 0 means masked. An accepted completion while the level is nonzero latches a pending request. `irq_req` is pending AND level nonzero, and `irq_level` shows the level while `irq_req` is 1 and shows 0 otherwise.
- R10: A read (`rd_en`) of offset 1 or 2 clears the pending request. If a completion is accepted in the same cycle, the new request wins.
- R11: Offsets 0 and 3 read back their written fields at the bit positions above, and all unassigned bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Write offset |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe (consumes interrupt on result offsets) |
| rd_addr | input | 2 | Read offset |
| rd_data | output | 8 | Read byte, combinational from `rd_addr` |
| fast_osc_sel | input | 1 | System is running on the high-speed oscillator |
| adc_clk_en | output | 1 | Converter clock enable |
| conv_start | output | 1 | One-cycle conversion launch |
| conv_chan | output | 3 | Selected analog input |
| conv_done_valid | input | 1 | Converter offers a result |
| conv_done_ready | output | 1 | Block takes the offered result |
| conv_done_data | input | 10 | Conversion result |
| conv_busy | output | 1 | Conversion outstanding |
| ref_port_oe | input | 1 | Spare port pin configured as output |
| ref_port_data | input | 1 | Spare port pin data register |
| tp_ref_req | input | 1 | Touch-panel controller reference request |
| ref_pin_oe | output | 1 | Reference switch pin output enable |
| ref_pin_level | output | 1 | Reference switch pin level (low = reference on) |
| irq_req | output | 1 | Completion interrupt request |
| irq_level | output | 2 | Completion interrupt level |

## Verification
The bench targets starts that arrive while busy, while the oscillator gate is off, or while the clock bit is clear. A design that lets any of these through would pulse `conv_start` a second time or stall `conv_busy`. It offers completion strobes while nothing is outstanding. A block that accepts them would overwrite the stored result. It reads a result byte in the same cycle as a new completion to show whether clear or set wins, and it runs completions with the level at 0 to catch an interrupt that fires while masked. It also flips the software reference bit while the touch controller owns the switch, and sweeps the port configuration, so that a wrong mux choice shows up on `ref_pin_level`.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFF_CTRL   = 2'd0,
    OFF_RES_HI = 2'd1,
    OFF_RES_LO = 2'd2,
    OFF_CFG    = 2'd3
  } reg_off_e;
endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [RES_W-1:0]  result,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_W-1:0]   chan,
  output logic              ref_on,
  output logic              ref_ext,
  output logic              clk_bit,
  output logic [PRIO_W-1:0] prio,
  output logic              start_req
);
  localparam int LO_W      = RES_W - DATA_W;
  localparam int REFON_BIT = CH_W;
  localparam int REFEX_BIT = CH_W + 1;
  localparam int START_BIT = DATA_W - 1;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  assign start_req = wr_en && (reg_off_e'(wr_addr) == OFF_CTRL) && wr_data[START_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan    <= '0;
      ref_on  <= 1'b0;
      ref_ext <= 1'b0;
      clk_bit <= 1'b0;
      prio    <= '0;
    end else if (wr_en) begin
      case (reg_off_e'(wr_addr))
        OFF_CTRL: begin
          chan    <= wr_data[CH_W-1:0];
          ref_on  <= wr_data[REFON_BIT];
          ref_ext <= wr_data[REFEX_BIT];
        end
        OFF_CFG: begin
          clk_bit <= wr_data[0];
          prio    <= wr_data[PRIO_W:1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_off_e'(rd_addr))
      OFF_CTRL:   rd_data = DATA_W'({ref_ext, ref_on, chan});
      OFF_RES_HI: rd_data = result[RES_W-1 -: DATA_W];
      OFF_RES_LO: rd_data = DATA_W'(result[LO_W-1:0]);
      OFF_CFG:    rd_data = DATA_W'({prio, clk_bit});
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             clk_gate_on,
  input  logic             done_valid,
  input  logic [RES_W-1:0] done_data,
  output logic             done_ready,
  output logic             conv_start,
  output logic             busy,
  output logic             accept,
  output logic [RES_W-1:0] result
);
  logic launch;

  assign done_ready = busy;
  assign accept     = done_valid && busy;
  assign launch     = start_req && clk_gate_on && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      result     <= '0;
    end else begin
      conv_start <= launch;
      if (accept) begin
        busy   <= 1'b0;
        result <= done_data;
      end else if (launch) begin
        busy <= 1'b1;
      end
    end
  end

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> !conv_start);
  a_r5_no_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_on |=> !conv_start);
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(result));
endmodule

// File: rtl/adc_ref_sel.sv
module adc_ref_sel (
  input  logic ref_on,
  input  logic ref_ext,
  input  logic tp_req,
  input  logic port_oe,
  input  logic port_data,
  output logic pin_oe,
  output logic pin_level
);
  logic active;

  assign active    = ref_ext ? tp_req : ref_on;
  assign pin_oe    = port_oe;
  assign pin_level = port_oe & port_data & ~active;
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen #(
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_clear,
  input  logic [PRIO_W-1:0] prio,
  output logic              irq_req,
  output logic [PRIO_W-1:0] irq_level
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (accept && (prio != '0)) begin
      pending <= 1'b1;
    end else if (rd_clear) begin
      pending <= 1'b0;
    end
  end

  assign irq_req   = pending && (prio != '0);
  assign irq_level = irq_req ? prio : '0;

  a_r9_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (prio != '0)) |=> pending);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !accept) |=> !irq_req);
  a_r9_masked_level: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == '0));
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fast_osc_sel,
  output logic              adc_clk_en,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done_valid,
  output logic              conv_done_ready,
  input  logic [RES_W-1:0]  conv_done_data,
  output logic              conv_busy,
  input  logic              ref_port_oe,
  input  logic              ref_port_data,
  input  logic              tp_ref_req,
  output logic              ref_pin_oe,
  output logic              ref_pin_level,
  output logic              irq_req,
  output logic [PRIO_W-1:0] irq_level
);
  logic [CH_W-1:0]   chan;
  logic [PRIO_W-1:0] prio;
  logic [RES_W-1:0]  result;
  logic ref_on, ref_ext, clk_bit, start_req, accept, rd_clear;

  assign adc_clk_en = clk_bit & fast_osc_sel;
  assign conv_chan  = chan;
  assign rd_clear   = rd_en && ((reg_off_e'(rd_addr) == OFF_RES_HI) ||
                                (reg_off_e'(rd_addr) == OFF_RES_LO));

  adc_cfg_regs #(.DATA_W(DATA_W), .RES_W(RES_W), .CH_W(CH_W), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .result(result), .rd_data(rd_data), .chan(chan),
    .ref_on(ref_on), .ref_ext(ref_ext), .clk_bit(clk_bit), .prio(prio),
    .start_req(start_req)
  );

  adc_conv_seq #(.RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .clk_gate_on(adc_clk_en),
    .done_valid(conv_done_valid), .done_data(conv_done_data),
    .done_ready(conv_done_ready), .conv_start(conv_start), .busy(conv_busy),
    .accept(accept), .result(result)
  );

  adc_ref_sel u_ref (
    .ref_on(ref_on), .ref_ext(ref_ext), .tp_req(tp_ref_req),
    .port_oe(ref_port_oe), .port_data(ref_port_data),
    .pin_oe(ref_pin_oe), .pin_level(ref_pin_level)
  );

  adc_irq_gen #(.PRIO_W(PRIO_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_clear(rd_clear),
    .prio(prio), .irq_req(irq_req), .irq_level(irq_level)
  );
endmodule

// File: tb/adc_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module adc_ctrl_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic fast_osc_sel = 1'b0;
  logic adc_clk_en, conv_start, conv_done_ready, conv_busy;
  logic [2:0] conv_chan;
  logic conv_done_valid = 1'b0;
  logic [9:0] conv_done_data = '0;
  logic ref_port_oe = 1'b0, ref_port_data = 1'b0, tp_ref_req = 1'b0;
  logic ref_pin_oe, ref_pin_level, irq_req;
  logic [1:0] irq_level;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  adc_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .fast_osc_sel(fast_osc_sel),
    .adc_clk_en(adc_clk_en), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done_valid(conv_done_valid), .conv_done_ready(conv_done_ready),
    .conv_done_data(conv_done_data), .conv_busy(conv_busy),
    .ref_port_oe(ref_port_oe), .ref_port_data(ref_port_data), .tp_ref_req(tp_ref_req),
    .ref_pin_oe(ref_pin_oe), .ref_pin_level(ref_pin_level),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  int m_chan, m_res, m_prio;
  bit m_ref_on, m_ref_ext, m_clk, m_busy, m_pend, m_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_chan = 0; m_res = 0; m_prio = 0; m_ref_on = 0; m_ref_ext = 0;
      m_clk = 0; m_busy = 0; m_pend = 0; m_start = 0;
    end else begin
      bit acc, go, rdc;
      acc = conv_done_valid && m_busy;
      go  = wr_en && wr_addr == 0 && wr_data[7] && m_clk && fast_osc_sel && !m_busy;
      rdc = rd_en && (rd_addr == 1 || rd_addr == 2);
      if (acc && m_prio != 0) m_pend = 1;
      else if (rdc) m_pend = 0;
      if (acc) begin m_res = int'(conv_done_data); m_busy = 0; end
      if (go) m_busy = 1;
      m_start = go;
      if (wr_en && wr_addr == 0) begin
        m_chan = wr_data & 7; m_ref_on = wr_data[3]; m_ref_ext = wr_data[4];
      end
      if (wr_en && wr_addr == 3) begin
        m_clk = wr_data[0]; m_prio = (wr_data >> 1) & 3;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      int exp_rd;
      bit act, irq_e;
      case (rd_addr)
        2'd0: exp_rd = (int'(m_ref_ext) << 4) | (int'(m_ref_on) << 3) | m_chan;
        2'd1: exp_rd = m_res >> 2;
        2'd2: exp_rd = m_res & 3;
        default: exp_rd = (m_prio << 1) | int'(m_clk);
      endcase
      chk(rd_addr == 1 || rd_addr == 2 ? "R6 rd_data" : "R11 rd_data", rd_data, exp_rd);
      chk("R2 adc_clk_en", adc_clk_en, m_clk && fast_osc_sel);
      chk("R3/R5 conv_start", conv_start, m_start);
      chk("R3 conv_busy", conv_busy, m_busy);
      chk("R6 conv_done_ready", conv_done_ready, m_busy);
      chk("R4 conv_chan", conv_chan, m_chan);
      act = m_ref_ext ? tp_ref_req : m_ref_on;
      chk("R7 ref_pin_oe", ref_pin_oe, ref_port_oe);
      chk(m_ref_ext ? "R8 ref_pin_level" : "R7 ref_pin_level", ref_pin_level,
          ref_port_oe && ref_port_data && !act);
      irq_e = m_pend && m_prio != 0;
      chk("R9/R10 irq_req", irq_req, irq_e);
      chk("R9 irq_level", irq_level, irq_e ? m_prio : 0);
    end
  end

  // Converter stub: answers LAT cycles after a start
  localparam int LAT = 4;
  int cnt = 0, seqv = 0, lchan = 0;
  bit stray_req = 0;
  always @(negedge clk) begin
    conv_done_valid = 1'b0;
    if (conv_start) begin
      cnt = LAT; lchan = int'(conv_chan);
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        seqv++;
        conv_done_valid = 1'b1;
        conv_done_data = 10'((lchan * 117 + seqv * 29 + 'h2A5) & 'h3FF);
      end
    end
    if (stray_req) begin
      stray_req = 0;
      conv_done_valid = 1'b1;
      conv_done_data = 10'((seqv * 53 + 'h155) & 'h3FF);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input int a);
    @(negedge clk); rd_en = 1; rd_addr = 2'(a);
    @(negedge clk); rd_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic stray();
    @(posedge clk); #2 stray_req = 1;
    idle(2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk("R1 reset rd_data", rd_data, 0);
    end
    chk("R1 reset adc_clk_en", adc_clk_en, 0);
    chk("R1 reset conv_start", conv_start, 0);
    chk("R1 reset conv_busy", conv_busy, 0);
    chk("R1 reset conv_done_ready", conv_done_ready, 0);
    chk("R1 reset irq_req", irq_req, 0);
    chk("R1 reset irq_level", irq_level, 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    // R5: start with clock bit clear is dropped
    fast_osc_sel = 1;
    wr(0, 'h82); idle(6);
    // R2: enable clock, level 2
    wr(3, 'h05); rd(3);
    // R3/R4: launch on channel 5, wait, read result (R6, R10)
    wr(0, 'h85); idle(8); rd(1); rd(2);
    // R3: bit 7 clear starts nothing
    wr(0, 'h03); idle(6);
    // R5: second start while busy
    wr(0, 'h86); wr(0, 'h87); idle(8);
    // R5: oscillator gate off drops start
    fast_osc_sel = 0; wr(0, 'h81); idle(6); fast_osc_sel = 1;
    // R6: stray strobes and writes to result offsets
    stray(); wr(1, 'hFF); wr(2, 'hFF); rd_addr = 2; idle(2); rd_addr = 1; idle(2);
    // R9: masked level
    wr(3, 'h01); wr(0, 'h84); idle(8); rd(2);
    // R10: read result in the cycle a completion is accepted
    wr(3, 'h07); wr(0, 'h80);
    idle(3); rd_en = 1; rd_addr = 1; idle(3); rd_en = 0; idle(2);
    // stray while busy is accepted as the completion
    wr(0, 'h81); stray(); idle(8); rd(1);
    // sweep channels and levels
    for (int c = 0; c < 8; c++) begin
      wr(3, 1 | ((c & 3) << 1));
      wr(0, 'h80 | c); idle(8);
      rd_addr = 0; idle(1);
      rd(c % 2 == 0 ? 1 : 2);
    end
    // R7/R8: reference pin control
    for (int p = 0; p < 4; p++) begin
      ref_port_oe = p[0]; ref_port_data = p[1];
      wr(0, 'h08); idle(1); wr(0, 'h00); idle(1);
      wr(0, 'h18); tp_ref_req = 0; idle(2); tp_ref_req = 1; idle(2);
      wr(0, 'h10); idle(1); tp_ref_req = 0; idle(2);
    end
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule